// File: doc/BRIEF.md
# Gated Final-Score Scale and Accumulate Unit

This unit post-processes each finished vector sum that an upstream accumulator delivers. Each sum is multiplied by a scale operand and then offset by a per-component weight. The arithmetic is signed fixed point and runs in a two-stage pipeline. Inputs arrive only now and then, so the datapath registers advance only in cycles that hold a valid input or an occupied first stage. In every other cycle they hold their value.

A mode input picks between two ways of handing results to the host. In pass-through mode every input produces one scored result on a valid-qualified output. In accumulate mode the results are summed into one of ten per-slot score registers, one for each interleaved vector slot. A slot raises its ready flag after its eighth contribution. The host then reads the slot through an addressed read port, and that read empties the slot. The host therefore makes one read per eight results.

Top module: `score_scale_acc`

## Requirements
- R1: In pass-through mode (`acc_mode`=0), an input accepted at a clock edge produces `out_valid`=1 for one cycle after the following edge, with `out_score` = `in_sum`*`scale`+`weight` (signed, sign-extended to OW bits) and `out_slot` = `in_slot`.
- R2: `busy` is 1 exactly when `in_valid` is 1 or the first pipeline stage holds an input. While it is 0, `out_score`, `out_slot` and the slot scores do not change, except when a host read clears a slot.
- R3: In accumulate mode (`acc_mode`=1, sampled with the input), `out_valid` stays 0 and the product-plus-weight is added into the score register chosen by `in_slot`.
- R4: Bit i of `ready` becomes 1 once slot i has taken exactly 8 contributions, and stays 0 after 7.
- R5: `rd_data` shows the score of slot `rd_slot` combinationally. `rd_en`=1 on a slot whose ready bit is 1 clears that score, its count and its ready bit at the next edge.
- R6: A contribution that reaches a slot while its ready bit is 1 is dropped, and the score is left unchanged.
- R7: If a read clears a slot at the same edge that a contribution for that slot is written, the slot restarts with that contribution alone, and the count becomes 1.
- R8: After reset, `out_valid`, `busy` and every `ready` bit are 0, and every slot reads 0.
- R9: `rd_en` on a slot whose ready bit is 0 has no effect on that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A finished vector sum is present |
| in_slot | input | SLW | Interleaved vector slot of the sum |
| in_sum | input | DW | Signed vector sum |
| scale | input | SW | Signed scale operand |
| weight | input | WW | Signed weight added after scaling |
| acc_mode | input | 1 | 0 pass-through, 1 accumulate per slot |
| busy | output | 1 | Datapath enable (activity) |
| out_valid | output | 1 | Pass-through result strobe |
| out_slot | output | SLW | Slot of the pass-through result |
| out_score | output | OW | Pass-through scaled score |
| ready | output | SLOTS | Per-slot accumulated score ready |
| rd_en | input | 1 | Read-and-clear request |
| rd_slot | input | SLW | Slot selected for reading |
| rd_data | output | OW | Score of the selected slot |

## Verification
The hardest case to reach is the collision in R7. A read must land on exactly the edge at which a contribution for the same slot leaves the first stage. The bench gets there by filling a slot to its ready state first. It then issues one further input for that slot, and raises `rd_en` in the next cycle, while that input sits in the first stage. Dropped contributions (R6) and ignored reads (R9) are checked by reading the slot back through `rd_data`.

// File: rtl/score_scale_acc.sv
module score_scale_acc #(
  parameter int DW    = 16,
  parameter int SW    = 16,
  parameter int WW    = 32,
  parameter int OW    = 40,
  parameter int SLOTS = 10,
  parameter int GROUP = 8,
  localparam int SLW  = $clog2(SLOTS),
  localparam int CW   = $clog2(GROUP + 1),
  localparam int PW   = DW + SW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [SLW-1:0]       in_slot,
  input  logic signed [DW-1:0] in_sum,
  input  logic signed [SW-1:0] scale,
  input  logic signed [WW-1:0] weight,
  input  logic                 acc_mode,
  output logic                 busy,
  output logic                 out_valid,
  output logic [SLW-1:0]       out_slot,
  output logic signed [OW-1:0] out_score,
  output logic [SLOTS-1:0]     ready,
  input  logic                 rd_en,
  input  logic [SLW-1:0]       rd_slot,
  output logic signed [OW-1:0] rd_data
);

  logic                 v1, m1;
  logic [SLW-1:0]       s1;
  logic signed [PW-1:0] p1;
  logic signed [WW-1:0] w1;
  logic signed [OW-1:0] score [SLOTS];
  logic [CW-1:0]        cnt   [SLOTS];

  wire en = in_valid | v1;
  assign busy = en;

  wire signed [OW-1:0] term = {{(OW-PW){p1[PW-1]}}, p1} + {{(OW-WW){w1[WW-1]}}, w1};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v1        <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1        <= in_valid;
      out_valid <= v1 & ~m1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m1        <= 1'b0;
      s1        <= '0;
      p1        <= '0;
      w1        <= '0;
      out_score <= '0;
      out_slot  <= '0;
    end else if (en) begin
      m1 <= acc_mode;
      s1 <= in_slot;
      p1 <= PW'(in_sum) * PW'(scale);
      w1 <= weight;
      if (v1 && !m1) begin
        out_score <= term;
        out_slot  <= s1;
      end
    end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    wire wr = v1 & m1 & (s1 == SLW'(i));
    wire rd = rd_en & (rd_slot == SLW'(i)) & ready[i];
    assign ready[i] = (cnt[i] == CW'(GROUP));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        score[i] <= '0;
        cnt[i]   <= '0;
      end else if (rd && wr) begin
        score[i] <= term;
        cnt[i]   <= CW'(1);
      end else if (rd) begin
        score[i] <= '0;
        cnt[i]   <= '0;
      end else if (wr && !ready[i]) begin
        score[i] <= score[i] + term;
        cnt[i]   <= cnt[i] + CW'(1);
      end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[i] <= CW'(GROUP));

    // R5
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_slot == SLW'(i) && ready[i]) |=> (!ready[i] && cnt[i] <= CW'(1)));

    // R6
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready[i] && !(rd_en && rd_slot == SLW'(i))) |=> (ready[i] && $stable(score[i])));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !v1 && !(rd_en && rd_slot == SLW'(i))) |=> $stable(score[i]));
  end

  assign rd_data = (rd_slot < SLW'(SLOTS)) ? score[rd_slot] : '0;

  // R2
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(out_score) && $stable(out_slot) && !out_valid));

  // R3
  acc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && m1) |=> !out_valid);

  // R1
  pass_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(v1));

endmodule

// File: tb/tb_score_scale_acc.sv
module tb_score_scale_acc;
  localparam int OW = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, acc_mode = 1'b0, rd_en = 1'b0;
  logic [3:0] in_slot = '0, rd_slot = '0;
  logic signed [15:0] in_sum = '0, scale = '0;
  logic signed [31:0] weight = '0;
  logic busy, out_valid;
  logic [3:0] out_slot;
  logic signed [OW-1:0] out_score, rd_data;
  logic [9:0] ready;

  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  score_scale_acc dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_slot(in_slot),
    .in_sum(in_sum), .scale(scale), .weight(weight), .acc_mode(acc_mode),
    .busy(busy), .out_valid(out_valid), .out_slot(out_slot), .out_score(out_score),
    .ready(ready), .rd_en(rd_en), .rd_slot(rd_slot), .rd_data(rd_data)
  );

  localparam int NV = 6;
  localparam int VS [NV] = '{100, -7, 32767, -32768, 0, -1};
  localparam int VK [NV] = '{3, 9, 32767, -32768, 1234, 32767};
  localparam int VW [NV] = '{5, -2, 0, -1, -99999, 7};

  function automatic longint f(longint s, longint k, longint w);
    return s * k + w;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic drive(int slot, int s, int k, int w);
    in_valid = 1'b1; in_slot = 4'(slot);
    in_sum = 16'(s); scale = 16'(k); weight = 32'(w);
    step();
  endtask

  task automatic flush();
    in_valid = 1'b0; step(); step();
  endtask

  task automatic rd(int slot, output longint v);
    rd_slot = 4'(slot); #1; v = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    longint v, e3, e7;
    step(); step();
    // R8 reset state
    chk("R8 out_valid", out_valid, 0);
    chk("R8 busy", busy, 0);
    chk("R8 ready", ready, 0);
    for (int i = 0; i < 10; i++) begin rd(i, v); chk("R8 slot", v, 0); end
    rst_n = 1'b1; step();

    // R1 pass-through vectors
    for (int n = 0; n < NV; n++) begin
      drive(n, VS[n], VK[n], VW[n]);
      in_valid = 1'b0;
      chk("R1 early", out_valid, 0);
      step();
      chk("R1 valid", out_valid, 1);
      chk("R1 score", out_score, f(VS[n], VK[n], VW[n]));
      chk("R1 slot", out_slot, n);
      step();
      chk("R1 pulse", out_valid, 0);
    end

    // R2 busy follows in_valid and the first stage
    in_valid = 1'b1; #1;
    chk("R2 busy on input", busy, 1);
    in_valid = 1'b0; #1;
    chk("R2 busy idle", busy, 0);

    // R3 / R4 accumulate interleaved slots 3 and 7
    acc_mode = 1'b1;
    e3 = 0; e7 = 0;
    for (int k = 0; k < 7; k++) begin
      drive(3, k + 1, 10, 4); e3 += f(k + 1, 10, 4);
      drive(7, -k, 5, 1);     e7 += f(-k, 5, 1);
    end
    flush();
    chk("R3 no strobe", out_valid, 0);
    chk("R4 not ready after 7", ready, 0);
    rd(3, v); chk("R3 partial slot3", v, e3);
    rd(7, v); chk("R3 partial slot7", v, e7);
    drive(3, 8, 10, 4); e3 += f(8, 10, 4);
    drive(7, -7, 5, 1); e7 += f(-7, 5, 1);
    flush();
    chk("R4 ready bits", ready, 10'b0010001000);
    rd(3, v); chk("R4 slot3 total", v, 392);
    rd(7, v); chk("R4 slot7 total", v, -132);

    // R6 contribution to a full slot is dropped
    drive(3, 50, 2, 0); flush();
    rd(3, v); chk("R6 slot3 held", v, 392);
    chk("R6 still ready", ready[3], 1);

    // R5 read clears
    rd_slot = 4'd3; rd_en = 1'b1; step(); rd_en = 1'b0;
    chk("R5 ready cleared", ready[3], 0);
    rd(3, v); chk("R5 slot cleared", v, 0);

    // R9 read of a slot that is not ready
    drive(5, 2, 3, 1); flush();
    rd_slot = 4'd5; rd_en = 1'b1; step(); rd_en = 1'b0;
    rd(5, v); chk("R9 slot5 kept", v, 7);

    // R7 read and write collide on slot 7
    drive(7, 4, 4, 4);
    in_valid = 1'b0; rd_slot = 4'd7; rd_en = 1'b1; step(); rd_en = 1'b0;
    chk("R7 ready cleared", ready[7], 0);
    rd(7, v); chk("R7 fresh score", v, 20);
    for (int k = 0; k < 7; k++) drive(7, 1, 1, 0);
    flush();
    chk("R7 count restarted at 1", ready[7], 1);
    rd(7, v); chk("R7 total", v, 27);

    // R2 hold while idle
    begin
      longint so, s5;
      so = out_score; rd(5, s5);
      for (int k = 0; k < 5; k++) begin
        in_sum = 16'(1000 + k); scale = 16'(-3 - k); weight = 32'(k * 77);
        acc_mode = k[0]; step();
        chk("R2 busy low", busy, 0);
      end
      chk("R2 out_score held", out_score, so);
      rd(5, v); chk("R2 slot5 held", v, s5);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule